// File: doc/BRIEF.md
# Lockable Non-Maskable Interrupt Edge Detector

This block turns one external pin into a non-maskable interrupt source. Out of reset the pin is only an ordinary input: its level can be read, but it raises no request. Software arms the source by writing a control word with the arm bit set. From then on the source stays armed until the next reset, and no later write can disarm it.

The pin is first brought into the clock domain by a synchronizer chain. The synchronized level is what software reads back. A programmable debounce filter then cleans the level, and a falling edge of the cleaned level raises a request. The request latches and stays up until the interrupt controller acknowledges it. Further falling edges that arrive while a request is pending fold into that same request. The debounce count runs from 0, which bypasses the filter, to 255, which is the setting used while the clock domain is in a low-power state.

Top module: `nmi_edge_ctrl`

## Requirements
- R1: `nmi_req_o` rises only after the debounced pin level has gone from 1 to 0 while the source is armed.
- R2: A write with `wr_addr_i`=0 and `wr_data_i[4]`=1 arms the source. A write to address 0 with bit 4 clear has no arming effect, whatever its other bits hold.
- R3: After reset the source is disarmed, `nmi_req_o` is 0, and pin edges raise no request until the source is armed.
- R4: Once armed, a write to address 0 with bit 4 clear leaves the source armed. Only reset disarms it.
- R5: A write with `wr_addr_i`=1 loads `wr_data_i[7:0]` as the debounce count D. With D>0, a new level is accepted only after the synchronized pin has differed from the accepted level for D consecutive clocks. A low pulse shorter than D clocks raises no request.
- R6: D=0 bypasses the filter, so a low pulse of a single clock raises a request.
- R7: D=255 is supported. A 254-clock low pulse is rejected and a 255-clock low pulse raises a request.
- R8: `pin_level_o` shows the pin level two clock edges after the pin changes. It does not depend on the arm state or on D.
- R9: A request stays at 1 until `nmi_ack_i` is sampled high, and it clears at that edge. If a new falling edge arrives in the same cycle as the acknowledge, the request stays at 1.
- R10: A second falling edge while a request is pending is merged into it, so a single acknowledge clears it.
- R11: With the pin steady high beforehand, `nmi_req_o` rises 3+max(D,1) clock edges after the pin goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pin_i | input | 1 | Raw external interrupt pin |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | 0: control word (bit 4 arms), 1: debounce count |
| wr_data_i | input | 8 | Write data |
| nmi_ack_i | input | 1 | Acknowledge from the interrupt controller, clears the pending request |
| pin_level_o | output | 1 | Synchronized raw pin level |
| nmi_req_o | output | 1 | Pending non-maskable interrupt request |

## Verification
The pin level is due two edges after a pin change. A request is due 3+max(D,1) edges after the pin falls. A clear is due one edge after the acknowledge is sampled. A register write takes effect at the edge that samples the strobe. The bench drives every input on the falling clock edge, counts rising edges from that point, and samples one edge before and exactly at the expected edge for the latency cases. Pulse-length cases wait a margin well past the worst latency for their D before they sample.

// File: rtl/nmi_pkg.sv
`timescale 1ns/1ps
package nmi_pkg;
  localparam int unsigned REG_W  = 8;
  localparam int unsigned ARM_BIT = 4;

  typedef enum logic {
    ADDR_CTRL = 1'b0,
    ADDR_DBNC = 1'b1
  } nmi_addr_e;
endpackage

// File: rtl/nmi_rst_sync.sv
`timescale 1ns/1ps
module nmi_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/nmi_pin_sync.sv
`timescale 1ns/1ps
module nmi_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic pin_o
);
  logic [STAGES-1:0] stg_q;
  logic [STAGES-1:0] stg_d;

  assign stg_d[0] = pin_i;
  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    assign stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '1;
    else        stg_q <= stg_d;
  end

  assign pin_o = stg_q[STAGES-1];
endmodule

// File: rtl/nmi_debounce.sv
`timescale 1ns/1ps
module nmi_debounce #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             out_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             filt_q, filt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bypass;
  logic             differs;
  logic             expired;

  assign bypass  = (lim_i == '0);
  assign differs = (in_i != filt_q);
  assign expired = (cnt_q >= (lim_i - ONE));

  always_comb begin
    filt_d = filt_q;
    cnt_d  = cnt_q;
    if (bypass) begin
      filt_d = in_i;
      cnt_d  = '0;
    end else if (!differs) begin
      cnt_d = '0;
    end else if (expired) begin
      filt_d = in_i;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign out_o = filt_q;

  // R5
  filt_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> (filt_q == $past(in_i)));
endmodule

// File: rtl/nmi_req_ctrl.sv
`timescale 1ns/1ps
module nmi_req_ctrl
  import nmi_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  nmi_addr_e        wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             filt_i,
  input  logic             ack_i,
  output logic [CNT_W-1:0] lim_o,
  output logic             req_o
);
  logic             arm_q, arm_d;
  logic [CNT_W-1:0] lim_q, lim_d;
  logic             prev_q;
  logic             req_q, req_d;
  logic             wr_ctrl, wr_dbnc;
  logic             fall;

  assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign wr_dbnc = wr_en_i && (wr_addr_i == ADDR_DBNC);
  assign fall    = prev_q && !filt_i;

  always_comb begin
    arm_d = arm_q | (wr_ctrl & wr_data_i[ARM_BIT]);
    lim_d = wr_dbnc ? wr_data_i[CNT_W-1:0] : lim_q;
    req_d = (fall & arm_q) | (req_q & ~ack_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      lim_q  <= '0;
      prev_q <= 1'b1;
      req_q  <= 1'b0;
    end else begin
      arm_q  <= arm_d;
      lim_q  <= lim_d;
      prev_q <= filt_i;
      req_q  <= req_d;
    end
  end

  assign lim_o = lim_q;
  assign req_o = req_q;

  // R4
  arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_q |=> arm_q);
  // R3
  req_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_q |-> arm_q);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !ack_i) |=> req_q);
endmodule

// File: rtl/nmi_edge_ctrl.sv
`timescale 1ns/1ps
module nmi_edge_ctrl
  import nmi_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RST_STAGES  = 2,
  parameter int unsigned CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_i,
  input  logic             wr_en_i,
  input  logic             wr_addr_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             nmi_ack_i,
  output logic             pin_level_o,
  output logic             nmi_req_o
);
  logic             rst_n_s;
  logic             pin_s;
  logic             filt_w;
  logic [CNT_W-1:0] lim_w;
  nmi_addr_e        addr_w;

  assign addr_w = nmi_addr_e'(wr_addr_i);

  nmi_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_n_o(rst_n_s)
  );

  nmi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n_s),
    .pin_i(pin_i),
    .pin_o(pin_s)
  );

  nmi_debounce #(.CNT_W(CNT_W)) u_dbnc (
    .clk  (clk),
    .rst_n(rst_n_s),
    .in_i (pin_s),
    .lim_i(lim_w),
    .out_o(filt_w)
  );

  nmi_req_ctrl #(.CNT_W(CNT_W)) u_req (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(addr_w),
    .wr_data_i(wr_data_i),
    .filt_i   (filt_w),
    .ack_i    (nmi_ack_i),
    .lim_o    (lim_w),
    .req_o    (nmi_req_o)
  );

  assign pin_level_o = pin_s;

  // R1
  req_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(nmi_req_o) |-> !$past(filt_w));
endmodule

// File: tb/test_nmi_edge_ctrl.sv
`timescale 1ns/1ps
module test_nmi_edge_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin;
  logic       wr_en;
  logic       wr_addr;
  logic [7:0] wr_data;
  logic       ack;
  logic       pin_level;
  logic       req;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  nmi_edge_ctrl i_nmi_edge_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (pin),
    .wr_en_i    (wr_en),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .nmi_ack_i  (ack),
    .pin_level_o(pin_level),
    .nmi_req_o  (req)
  );

  typedef struct packed {
    logic [7:0] dbc;
    logic [8:0] len;
    logic       exp;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{8'd0,   9'd1,   1'b1},
    '{8'd1,   9'd1,   1'b1},
    '{8'd3,   9'd2,   1'b0},
    '{8'd3,   9'd3,   1'b1},
    '{8'd5,   9'd4,   1'b0},
    '{8'd5,   9'd9,   1'b1},
    '{8'd16,  9'd15,  1'b0},
    '{8'd16,  9'd16,  1'b1},
    '{8'd255, 9'd254, 1'b0},
    '{8'd255, 9'd255, 1'b1}
  };

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic addr, input logic [7:0] data);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input int len);
    pin = 1'b0;
    repeat (len) @(negedge clk);
    pin = 1'b1;
  endtask

  task automatic give_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; pin = 1'b1; wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0; ack = 1'b0;
    idle(4);
    chk(req, 1'b0, "R3 reset request");
    chk(pin_level, 1'b1, "R8 reset pin level");
    rst_n = 1'b1;
    idle(5);

    // disarmed: no request
    pulse(5); idle(10);
    chk(req, 1'b0, "R3 disarmed edge");
    // bit 4 clear, others set: still disarmed
    wr(1'b0, 8'hEF);
    pulse(5); idle(10);
    chk(req, 1'b0, "R2 other bits do not arm");

    // pin level independent of filter and arm state
    wr(1'b1, 8'd20);
    pin = 1'b0;
    idle(1);
    chk(pin_level, 1'b1, "R8 level after one edge");
    idle(1);
    chk(pin_level, 1'b0, "R8 level after two edges");
    pin = 1'b1;
    idle(2);
    chk(pin_level, 1'b1, "R8 level back high");
    idle(30);

    // arm and measure latency with D=0
    wr(1'b0, 8'h10);
    wr(1'b1, 8'd0);
    idle(5);
    pin = 1'b0;
    idle(3);
    chk(req, 1'b0, "R11 D=0 one edge early");
    idle(1);
    chk(req, 1'b1, "R11 D=0 on time");
    pin = 1'b1;
    idle(20);
    chk(req, 1'b1, "R9 request held");
    give_ack();
    chk(req, 1'b0, "R9 cleared by acknowledge");

    // latency with D=6
    wr(1'b1, 8'd6);
    idle(20);
    pin = 1'b0;
    idle(8);
    chk(req, 1'b0, "R11 D=6 one edge early");
    idle(1);
    chk(req, 1'b1, "R11 D=6 on time");
    pin = 1'b1;
    idle(20);
    give_ack();

    // disarm attempt
    wr(1'b0, 8'h00);
    wr(1'b1, 8'd0);
    idle(5);
    pulse(2); idle(10);
    chk(req, 1'b1, "R4 write of zero ignored");
    give_ack();

    // table of debounce settings and pulse lengths
    for (int i = 0; i < NVEC; i++) begin
      wr(1'b1, VECS[i].dbc);
      idle(2 * int'(VECS[i].dbc) + 10);
      give_ack();
      chk(req, 1'b0, "R5 clear before vector");
      pulse(int'(VECS[i].len));
      idle(int'(VECS[i].dbc) + 12);
      if (VECS[i].dbc == 8'd0)        chk(req, VECS[i].exp, "R6 bypass pulse");
      else if (VECS[i].dbc == 8'd255) chk(req, VECS[i].exp, "R7 full count pulse");
      else                            chk(req, VECS[i].exp, "R5 debounce pulse");
      idle(int'(VECS[i].dbc) + 5);
    end

    // merge of two edges
    wr(1'b1, 8'd0);
    idle(5);
    give_ack();
    pulse(2); idle(8);
    pulse(2); idle(8);
    chk(req, 1'b1, "R10 two edges pending");
    give_ack();
    chk(req, 1'b0, "R10 single acknowledge clears");
    idle(5);
    chk(req, 1'b0, "R10 no queued request");

    // acknowledge in the same cycle as a new edge
    pulse(2); idle(8);
    pin = 1'b0;
    idle(3);
    ack = 1'b1;
    idle(1);
    ack = 1'b0;
    chk(req, 1'b1, "R9 new edge beats acknowledge");
    pin = 1'b1;
    idle(5);
    give_ack();
    chk(req, 1'b0, "R9 later acknowledge clears");

    // reset disarms
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(5);
    chk(req, 1'b0, "R4 reset clears request");
    pulse(3); idle(10);
    chk(req, 1'b0, "R4 reset disarms");

    finish_run();
  end
endmodule